// File: doc/BRIEF.md
# Disk Attachment Command Issue Sequencer

This block drives the register port of a disk controller attachment and delivers one command per request. When `start` is pulsed it runs the attention handshake. It switches the attachment's interrupts off, polls the busy flag up to a set number of times, writes the attention byte, and switches interrupts back on. It then pushes the command block, two or four 16-bit words, into the command interface register. After each word it waits for the attachment to drain that register.

The sequencer reaches the attachment through a single request/acknowledge port. Only one access is in flight at a time. The port has four word addresses: control at 0, status at 1, attention at 2 and command interface at 3. In the status word, bit 0 means busy and bit 1 means the command register is full. Writing 1 to bit 0 of the control word enables interrupts, and writing 0 disables them. The block ends each request with a one-cycle `done` pulse, or with a one-cycle `err` pulse if either poll runs past its limit.

Top module: `dsk_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `reg_req` are all low.
- R2: An accepted request produces these accesses in order: a write of 0 to control (address 0), status reads (address 1), a write to attention (address 2), and a write of 1 to control (address 0).
- R3: When `ack_reset` is high at start, no status read comes between the control write of 0 and the attention write.
- R4: If status bit 0 reads 1 on `BUSY_LIMIT` consecutive reads, the sequencer pulses `err` and makes no further access. If bit 0 reads 0 on any of those reads, the sequence goes on.
- R5: The attention write data is the device number in bits 7:5 and the attention type in bits 4:0, with bits 15:8 zero.
- R6: Each command word is written to address 3. After each word, status is read until bit 1 reads 0, and only then is the next word written.
- R7: If status bit 1 reads 1 on `FULL_LIMIT` consecutive reads after a word, the sequencer pulses `err` and writes no further word.
- R8: Word 0 is formed as follows. The command code sits in bits 4:0 and the device number in bits 7:5. The options byte is shifted left by 8 and ORed in. Bit 14 is set when the block is four words long.
- R9: With `long_cmd` low, word 0 and `arg1` are sent. With `long_cmd` high, word 0, `arg1`, `arg2` and `arg3` are sent, in that order.
- R10: `start` is taken only while `busy` is low. `busy` stays high until the cycle of the `done` or `err` pulse and falls the cycle after. `done` and `err` each last one cycle and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| ack_reset | input | 1 | Attention acknowledges a reset completion; skip busy poll |
| dev_num | input | 3 | Device number |
| attn_type | input | 5 | Attention type code |
| cmd_code | input | 5 | Command code |
| cmd_opt | input | 8 | Command options byte |
| long_cmd | input | 1 | Four-word block when high, two-word block when low |
| arg1 | input | 16 | Command word 1 |
| arg2 | input | 16 | Command word 2 |
| arg3 | input | 16 | Command word 3 |
| busy | output | 1 | Request in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Timeout pulse |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 2 | Register word address |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | Access complete |

## Verification
Two things can land on the same status read: the flag under poll clearing, and the retry count reaching its limit. The bench sets up the attachment model so that the flag clears on exactly the last permitted read. That run must finish with `done` and a full access trace. One more busy read must instead end in `err`, with no attention write. The same pair is tested on the command-full poll. A second `start` is also driven during a run, and the access trace is compared to confirm it left no mark.

// File: rtl/dsk_cmd_seq.sv
module dsk_cmd_seq #(
  parameter int BUSY_LIMIT = 10000,
  parameter int FULL_LIMIT = 10000,
  parameter int LONG_BIT   = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ack_reset,
  input  logic [2:0]  dev_num,
  input  logic [4:0]  attn_type,
  input  logic [4:0]  cmd_code,
  input  logic [7:0]  cmd_opt,
  input  logic        long_cmd,
  input  logic [15:0] arg1,
  input  logic [15:0] arg2,
  input  logic [15:0] arg3,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        reg_req,
  output logic        reg_we,
  output logic [1:0]  reg_addr,
  output logic [15:0] reg_wdata,
  input  logic [15:0] reg_rdata,
  input  logic        reg_ack
);
  localparam int MAXL = (BUSY_LIMIT > FULL_LIMIT) ? BUSY_LIMIT : FULL_LIMIT;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_ATTN = 2'd2, A_CMD = 2'd3;

  typedef enum logic [3:0] {
    IDLE, CTL_OFF, POLL_BSY, WR_ATTN, CTL_ON, WR_WORD, POLL_FULL, FIN, FAIL
  } st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  idx, last;
  logic        skip;
  logic [7:0]  attn_byte;
  logic [15:0] words [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      idx <= '0;
      last <= '0;
      skip <= 1'b0;
      attn_byte <= '0;
      for (int i = 0; i < 4; i++) words[i] <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st <= CTL_OFF;
          cnt <= '0;
          idx <= '0;
          skip <= ack_reset;
          last <= long_cmd ? 2'd3 : 2'd1;
          attn_byte <= {dev_num, attn_type};
          words[0] <= ({cmd_opt, 8'h00} | ({15'd0, long_cmd} << LONG_BIT)) | {8'h00, dev_num, cmd_code};
          words[1] <= arg1;
          words[2] <= arg2;
          words[3] <= arg3;
        end
        CTL_OFF: if (reg_ack) st <= skip ? WR_ATTN : POLL_BSY;
        POLL_BSY: if (reg_ack) begin
          if (!reg_rdata[0]) st <= WR_ATTN;
          else if (cnt == CW'(BUSY_LIMIT - 1)) st <= FAIL;
          else cnt <= cnt + 1'b1;
        end
        WR_ATTN: if (reg_ack) st <= CTL_ON;
        CTL_ON: if (reg_ack) st <= WR_WORD;
        WR_WORD: if (reg_ack) begin
          st <= POLL_FULL;
          cnt <= '0;
        end
        POLL_FULL: if (reg_ack) begin
          if (!reg_rdata[1]) begin
            if (idx == last) st <= FIN;
            else begin
              idx <= idx + 1'b1;
              st <= WR_WORD;
            end
          end else if (cnt == CW'(FULL_LIMIT - 1)) st <= FAIL;
          else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign busy = (st != IDLE);
  assign done = (st == FIN);
  assign err  = (st == FAIL);
  assign reg_req = (st != IDLE) && (st != FIN) && (st != FAIL);

  always_comb begin
    reg_we = 1'b1;
    reg_addr = A_CTRL;
    reg_wdata = '0;
    case (st)
      POLL_BSY, POLL_FULL: begin
        reg_we = 1'b0;
        reg_addr = A_STAT;
      end
      WR_ATTN: begin
        reg_addr = A_ATTN;
        reg_wdata = {8'h00, attn_byte};
      end
      CTL_ON: reg_wdata = 16'h0001;
      WR_WORD: begin
        reg_addr = A_CMD;
        reg_wdata = words[idx];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dsk_cmd_seq_chk.sv
module dsk_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        reg_req,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_ack
);
  a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n) (done || err) |=> !(done || err) && !busy);
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n) busy && !done && !err |=> busy);
  a_r10_take_start: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !reg_req);
endmodule

bind dsk_cmd_seq dsk_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_ack(reg_ack)
);

// File: tb/test_dsk_cmd_seq.sv
`timescale 1ns/1ps
module test_dsk_cmd_seq;
  localparam int LIM = 4;
  logic clk = 0, rst_n = 0;
  logic start = 0, ack_reset = 0, long_cmd = 0;
  logic [2:0] dev_num = 0;
  logic [4:0] attn_type = 0, cmd_code = 0;
  logic [7:0] cmd_opt = 0;
  logic [15:0] arg1 = 0, arg2 = 0, arg3 = 0;
  logic busy, done, err, reg_req, reg_we, reg_ack;
  logic [1:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  always #10 clk = ~clk;

  dsk_cmd_seq #(.BUSY_LIMIT(LIM), .FULL_LIMIT(LIM)) i_dsk_cmd_seq (.*);

  int errors = 0, checks = 0;
  int busy_left, full_per_word, full_left;
  logic [18:0] lg [0:63];
  logic [18:0] ex [0:63];
  int nlog, nex, ndone, nerr;

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_ack <= 0;
      reg_rdata <= 0;
    end else begin
      reg_ack <= reg_req && !reg_ack;
      if (reg_req && !reg_ack) begin
        if (nlog < 64) lg[nlog] <= {reg_we, reg_addr, reg_we ? reg_wdata : 16'h0};
        nlog <= nlog + 1;
        if (reg_we && reg_addr == 2'd3) full_left <= full_per_word;
        if (!reg_we) begin
          reg_rdata <= {14'd0, full_left > 0, busy_left > 0};
          if (busy_left > 0) busy_left <= busy_left - 1;
          if (full_left > 0) full_left <= full_left - 1;
        end
      end
      if (done) ndone <= ndone + 1;
      if (err) nerr <= nerr + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [1:0] a, input logic [15:0] d);
    ex[nex] = {we, a, d};
    nex++;
  endtask

  // expected trace from requirements R2-R9
  task automatic expect_trace(input logic skip, input int bsy, input int full, input logic lng,
                              input logic [15:0] w0, input int stop_word);
    logic [15:0] w [4];
    int nw, rb;
    w[0] = w0; w[1] = arg1; w[2] = arg2; w[3] = arg3;
    nw = lng ? 4 : 2;
    nex = 0;
    push(1, 0, 0);
    if (!skip) begin
      rb = (bsy >= LIM) ? LIM : bsy + 1;
      for (int i = 0; i < rb; i++) push(0, 1, 0);
      if (bsy >= LIM) return;
    end
    push(1, 2, {8'h00, dev_num, attn_type});
    push(1, 0, 16'h0001);
    for (int k = 0; k < nw; k++) begin
      push(1, 3, w[k]);
      rb = (full >= LIM) ? LIM : full + 1;
      for (int i = 0; i < rb; i++) push(0, 1, 0);
      if (full >= LIM || k == stop_word) return;
    end
  endtask

  task automatic run(input string req, input int bsy, input int full, input logic exp_err,
                     input logic extra_start);
    int t;
    @(negedge clk);
    busy_left = bsy; full_per_word = full; full_left = 0;
    nlog = 0; ndone = 0; nerr = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk({req, " busy after start (R10)"}, busy, 1);
    if (extra_start) begin
      repeat (3) @(negedge clk);
      start = 1; dev_num = ~dev_num; cmd_code = ~cmd_code;
      @(negedge clk);
      start = 0; dev_num = ~dev_num; cmd_code = ~cmd_code;
    end
    t = 0;
    while (busy && t < 1000) begin @(negedge clk); t++; end
    chk({req, " finished (R10)"}, t < 1000, 1);
    repeat (3) @(negedge clk);
    chk({req, " done count (R10)"}, ndone, exp_err ? 0 : 1);
    chk({req, " err count (R4/R7)"}, nerr, exp_err ? 1 : 0);
    chk({req, " access count"}, nlog, nex);
    for (int i = 0; i < nex && i < nlog; i++) chk({req, " access"}, lg[i], ex[i]);
  endtask

  function automatic logic [15:0] w0f();
    return ({cmd_opt, 8'h00} | (long_cmd ? 16'h4000 : 16'h0)) | {8'h00, dev_num, cmd_code};
  endfunction

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 err", err, 0); chk("R1 req", reg_req, 0);
  endtask

  task automatic t_long;
    dev_num = 3'd1; attn_type = 5'd3; cmd_code = 5'd1; cmd_opt = 8'h02; long_cmd = 1;
    arg1 = 16'h0010; arg2 = 16'hA5C3; arg3 = 16'h001F; ack_reset = 0;
    chk("R8 word0 value", w0f(), 16'h4221);
    expect_trace(0, 2, 1, 1, w0f(), 9);
    run("R2 R5 R6 R8 R9 long", 2, 1, 0, 0);
  endtask

  task automatic t_short;
    dev_num = 3'd6; attn_type = 5'd1; cmd_code = 5'd9; cmd_opt = 8'h00; long_cmd = 0;
    arg1 = 16'h1234;
    expect_trace(0, 0, 0, 0, w0f(), 9);
    run("R9 short", 0, 0, 0, 0);
  endtask

  task automatic t_skip;
    ack_reset = 1; dev_num = 3'd7; attn_type = 5'd2; long_cmd = 0;
    expect_trace(1, 5, 2, 0, w0f(), 9);
    run("R3 skip poll", 5, 2, 0, 0);
    ack_reset = 0;
  endtask

  task automatic t_busy_edge;
    expect_trace(0, LIM - 1, 0, 0, w0f(), 9);
    run("R4 clear on last read", LIM - 1, 0, 0, 0);
    expect_trace(0, LIM, 0, 0, w0f(), 9);
    run("R4 busy timeout", LIM, 0, 1, 0);
  endtask

  task automatic t_full_edge;
    long_cmd = 1;
    expect_trace(0, 0, LIM - 1, 1, w0f(), 9);
    run("R6 full clear on last read", 0, LIM - 1, 0, 0);
    expect_trace(0, 0, LIM, 1, w0f(), 0);
    run("R7 full timeout", 0, LIM, 1, 0);
  endtask

  task automatic t_restart;
    long_cmd = 1; dev_num = 3'd2; cmd_code = 5'd4;
    expect_trace(0, 1, 1, 1, w0f(), 9);
    run("R10 start while busy", 1, 1, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_long;
    t_short;
    t_skip;
    t_busy_edge;
    t_full_edge;
    t_restart;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule